// File: doc/BRIEF.md
# Out-of-Order Operand Station with Tag Renaming

This block sits in front of a single execution unit. It has a small pool of holding slots and a rename table that covers the architectural registers. An instruction arrives on the dispatch port with an opcode, a destination register and two source registers. The block places it in a free slot. For each source, the rename table returns either the current value or the tag of the slot that will produce that value. The destination register is then pointed at the new slot's tag. From that point on, later readers of that register wait for the new producer. Readers that were dispatched earlier keep whatever they already captured.

The execution unit returns each finished result on one shared result bus, carrying a tag and a value. Every slot still missing an operand compares that tag against the tags it is waiting for, and captures the value when they match. The rename table writes the value into the architectural register only if that producer is still the newest writer of the register.

When a slot has both operands, it becomes eligible to go to the unit. Among the eligible slots, the one dispatched earliest is sent, whatever its index. A slot stays occupied after it is sent, and is released when its own tag appears on the result bus. The unit is assumed to take one operation per cycle. The tag of a slot is its index.

Top module: `rs_station`

## Requirements
- R1: After reset, all slots are free, `disp_ready_o` is 1, `issue_valid_o` is 0, and every architectural register reads as value 0 with no pending producer.
- R2: A dispatch taken when `disp_valid_i` and `disp_ready_o` are both 1 is written into the lowest-numbered free slot. The tag of that slot equals its index.
- R3: A source register with no pending producer supplies its stored value. A source with a pending producer records that producer's tag. If that producer is on the result bus in the same cycle, the bus value is taken directly.
- R4: A slot whose two operands are both present is offered on the issue port (`issue_valid_o`, tag, opcode, both operands) starting in the cycle after the edge that completed it. It is offered exactly once.
- R5: A slot waiting on tag t captures the result-bus value into that operand at the edge where the bus carries tag t.
- R6: At most one slot issues per cycle. When several are eligible, the one dispatched earliest goes first, regardless of index.
- R7: A sent slot stays occupied until its tag is broadcast. It becomes free in the cycle after that broadcast, and not in the broadcast cycle itself.
- R8: `disp_ready_o` is 0 exactly when every slot is occupied. A dispatch presented while it is 0 is dropped.
- R9: A dispatch writing register r while another producer of r is still pending is accepted without stall. Readers dispatched later wait for the new tag, and earlier readers keep the older producer's value.
- R10: A broadcast whose tag is no longer the newest producer of r leaves r's value unchanged and r still pending on the newer tag.
- R11: When an instruction's destination register is also one of its sources, that source uses the mapping in force before this instruction's own rename.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A slot is free; dispatch will be taken |
| disp_op_i | input | OP_W | Opcode carried to the unit |
| disp_rd_i | input | clog2(N_REGS) | Destination register |
| disp_rs1_i | input | clog2(N_REGS) | First source register |
| disp_rs2_i | input | clog2(N_REGS) | Second source register |
| issue_valid_o | output | 1 | An operation is sent to the unit this cycle |
| issue_tag_o | output | clog2(N_ENTRIES) | Tag of the sent slot |
| issue_op_o | output | OP_W | Opcode of the sent slot |
| issue_a_o | output | DATA_W | First operand value |
| issue_b_o | output | DATA_W | Second operand value |
| bc_valid_i | input | 1 | Result bus carries a result |
| bc_tag_i | input | clog2(N_ENTRIES) | Tag of the producing slot |
| bc_value_i | input | DATA_W | Result value |

## Verification
Every result of this block is due one clock edge after its cause. A dispatch with both operands available shows up on the issue port in the next cycle. So does a slot completed by a capture from the result bus. A broadcast frees its slot, and `disp_ready_o` reflects that freed slot, in the cycle after the broadcast edge. The dispatch port's readiness depends only on registered state, so it is checked in the same cycle as the stimulus. The bench applies each stimulus at the falling edge and reads outputs one time unit before the next rising edge. A single cycle's expected row therefore pairs that cycle's inputs with outputs produced by the state from earlier edges. The expected values are worked out by walking the pool one edge at a time.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Life cycle of one holding slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,   // available for dispatch
        SLOT_WAIT = 2'd1,   // holding, collecting operands
        SLOT_SENT = 2'd2    // handed to the unit, result not yet broadcast
    } slot_state_e;

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4,
    parameter int TAG_W   = 2,
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [OP_W-1:0]   load_op_i,
    input  logic              load_a_rdy_i,
    input  logic [TAG_W-1:0]  load_a_tag_i,
    input  logic [DATA_W-1:0] load_a_val_i,
    input  logic              load_b_rdy_i,
    input  logic [TAG_W-1:0]  load_b_tag_i,
    input  logic [DATA_W-1:0] load_b_val_i,
    input  logic              grant_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i,
    output logic              busy_o,
    output logic              sent_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);

    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(SLOT_ID);

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        slot_state_e      state;
        logic [OP_W-1:0]  op;
        opnd_t            a;
        opnd_t            b;
    } slot_t;

    slot_t slot_d, slot_q;

    // Take a broadcast value into a missing operand whose tag matches
    function automatic opnd_t snoop(opnd_t cur, logic bv, logic [TAG_W-1:0] bt,
                                    logic [DATA_W-1:0] bd);
        opnd_t nxt;
        nxt = cur;
        if (!cur.rdy && bv && (cur.tag == bt)) begin
            nxt.rdy = 1'b1;
            nxt.val = bd;
        end
        return nxt;
    endfunction

    always_comb begin
        slot_d = slot_q;
        unique case (slot_q.state)
            SLOT_FREE: begin
                if (load_i) begin
                    slot_d.state = SLOT_WAIT;
                    slot_d.op    = load_op_i;
                    slot_d.a     = '{rdy: load_a_rdy_i, tag: load_a_tag_i, val: load_a_val_i};
                    slot_d.b     = '{rdy: load_b_rdy_i, tag: load_b_tag_i, val: load_b_val_i};
                end
            end
            SLOT_WAIT: begin
                slot_d.a = snoop(slot_q.a, bc_valid_i, bc_tag_i, bc_value_i);
                slot_d.b = snoop(slot_q.b, bc_valid_i, bc_tag_i, bc_value_i);
                if (grant_i) begin
                    slot_d.state = SLOT_SENT;
                end
            end
            SLOT_SENT: begin
                if (bc_valid_i && (bc_tag_i == OWN_TAG)) begin
                    slot_d.state = SLOT_FREE;
                end
            end
            default: slot_d.state = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{state: SLOT_FREE, op: '0, a: '0, b: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy_o  = (slot_q.state != SLOT_FREE);
    assign sent_o  = (slot_q.state == SLOT_SENT);
    assign ready_o = (slot_q.state == SLOT_WAIT) && slot_q.a.rdy && slot_q.b.rdy;
    assign op_o    = slot_q.op;
    assign a_o     = slot_q.a.val;
    assign b_o     = slot_q.b.val;

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N     = 4,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     alloc_i,
    input  logic [N-1:0]     ready_i,
    output logic [N-1:0]     grant_o,
    output logic [TAG_W-1:0] grant_idx_o,
    output logic             grant_any_o
);

    // older[x][y] set: slot x was loaded before slot y
    typedef struct packed {
        logic [N-1:0][N-1:0] older;
    } age_t;

    age_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        for (int k = 0; k < N; k++) begin
            if (alloc_i[k]) begin
                for (int j = 0; j < N; j++) begin
                    age_d.older[k][j] = 1'b0;
                    age_d.older[j][k] = (j != k);
                end
            end
        end
    end

    always_comb begin
        grant_o     = '0;
        grant_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if ((j != i) && ready_i[j] && age_q.older[j][i]) begin
                    blocked = 1'b1;
                end
            end
            grant_o[i] = ready_i[i] && !blocked;
        end
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                grant_idx_o = TAG_W'(i);
            end
        end
    end

    assign grant_any_o = |grant_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/rs_rename.sv
module rs_rename #(
    parameter int N_REGS = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rs1_i,
    input  logic [REG_W-1:0]  rs2_i,
    input  logic              rename_i,
    input  logic [REG_W-1:0]  rd_i,
    input  logic [TAG_W-1:0]  new_tag_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i,
    output logic              src1_rdy_o,
    output logic [TAG_W-1:0]  src1_tag_o,
    output logic [DATA_W-1:0] src1_val_o,
    output logic              src2_rdy_o,
    output logic [TAG_W-1:0]  src2_tag_o,
    output logic [DATA_W-1:0] src2_val_o
);

    typedef struct packed {
        logic [N_REGS-1:0][DATA_W-1:0] val;
        logic [N_REGS-1:0]             pend;
        logic [N_REGS-1:0][TAG_W-1:0]  tag;
    } table_t;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } lookup_t;

    table_t tbl_d, tbl_q;
    lookup_t look1, look2;

    // Source read with same-cycle bypass from the result bus
    function automatic lookup_t read_src(table_t t, logic [REG_W-1:0] r, logic bv,
                                         logic [TAG_W-1:0] bt, logic [DATA_W-1:0] bd);
        lookup_t res;
        res.tag = t.tag[r];
        if (!t.pend[r]) begin
            res.rdy = 1'b1;
            res.val = t.val[r];
        end else if (bv && (t.tag[r] == bt)) begin
            res.rdy = 1'b1;
            res.val = bd;
        end else begin
            res.rdy = 1'b0;
            res.val = '0;
        end
        return res;
    endfunction

    always_comb begin
        look1 = read_src(tbl_q, rs1_i, bc_valid_i, bc_tag_i, bc_value_i);
        look2 = read_src(tbl_q, rs2_i, bc_valid_i, bc_tag_i, bc_value_i);
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int r = 0; r < N_REGS; r++) begin
            if (bc_valid_i && tbl_q.pend[r] && (tbl_q.tag[r] == bc_tag_i)) begin
                tbl_d.val[r]  = bc_value_i;
                tbl_d.pend[r] = 1'b0;
            end
        end
        if (rename_i) begin
            tbl_d.pend[rd_i] = 1'b1;
            tbl_d.tag[rd_i]  = new_tag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign src1_rdy_o = look1.rdy;
    assign src1_tag_o = look1.tag;
    assign src1_val_o = look1.val;
    assign src2_rdy_o = look2.rdy;
    assign src2_tag_o = look2.tag;
    assign src2_val_o = look2.val;

endmodule

// File: rtl/rs_station.sv
module rs_station #(
    parameter int N_ENTRIES = 4,
    parameter int N_REGS    = 8,
    parameter int DATA_W    = 16,
    parameter int OP_W      = 4,
    localparam int TAG_W    = $clog2(N_ENTRIES),
    localparam int REG_W    = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid_i,
    output logic              disp_ready_o,
    input  logic [OP_W-1:0]   disp_op_i,
    input  logic [REG_W-1:0]  disp_rd_i,
    input  logic [REG_W-1:0]  disp_rs1_i,
    input  logic [REG_W-1:0]  disp_rs2_i,
    output logic              issue_valid_o,
    output logic [TAG_W-1:0]  issue_tag_o,
    output logic [OP_W-1:0]   issue_op_o,
    output logic [DATA_W-1:0] issue_a_o,
    output logic [DATA_W-1:0] issue_b_o,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_value_i
);

    logic [N_ENTRIES-1:0]             busy_vec;
    logic [N_ENTRIES-1:0]             sent_vec;
    logic [N_ENTRIES-1:0]             ready_vec;
    logic [N_ENTRIES-1:0]             grant_vec;
    logic [N_ENTRIES-1:0]             alloc_vec;
    logic [N_ENTRIES-1:0][OP_W-1:0]   slot_op;
    logic [N_ENTRIES-1:0][DATA_W-1:0] slot_a;
    logic [N_ENTRIES-1:0][DATA_W-1:0] slot_b;
    logic [TAG_W-1:0]                 alloc_tag;
    logic [TAG_W-1:0]                 grant_idx;
    logic                             grant_any;
    logic                             disp_fire;

    logic              s1_rdy, s2_rdy;
    logic [TAG_W-1:0]  s1_tag, s2_tag;
    logic [DATA_W-1:0] s1_val, s2_val;

    // Lowest-numbered free slot receives the next dispatch
    always_comb begin
        alloc_tag = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                alloc_tag = TAG_W'(i);
            end
        end
    end

    assign disp_ready_o = !(&busy_vec);
    assign disp_fire    = disp_valid_i && disp_ready_o;

    always_comb begin
        alloc_vec = '0;
        if (disp_fire) begin
            alloc_vec[alloc_tag] = 1'b1;
        end
    end

    rs_rename #(
        .N_REGS (N_REGS),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .REG_W  (REG_W)
    ) i_rename (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs1_i      (disp_rs1_i),
        .rs2_i      (disp_rs2_i),
        .rename_i   (disp_fire),
        .rd_i       (disp_rd_i),
        .new_tag_i  (alloc_tag),
        .bc_valid_i (bc_valid_i),
        .bc_tag_i   (bc_tag_i),
        .bc_value_i (bc_value_i),
        .src1_rdy_o (s1_rdy),
        .src1_tag_o (s1_tag),
        .src1_val_o (s1_val),
        .src2_rdy_o (s2_rdy),
        .src2_tag_o (s2_tag),
        .src2_val_o (s2_val)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        rs_slot #(
            .DATA_W  (DATA_W),
            .OP_W    (OP_W),
            .TAG_W   (TAG_W),
            .SLOT_ID (g)
        ) i_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (alloc_vec[g]),
            .load_op_i    (disp_op_i),
            .load_a_rdy_i (s1_rdy),
            .load_a_tag_i (s1_tag),
            .load_a_val_i (s1_val),
            .load_b_rdy_i (s2_rdy),
            .load_b_tag_i (s2_tag),
            .load_b_val_i (s2_val),
            .grant_i      (grant_vec[g]),
            .bc_valid_i   (bc_valid_i),
            .bc_tag_i     (bc_tag_i),
            .bc_value_i   (bc_value_i),
            .busy_o       (busy_vec[g]),
            .sent_o       (sent_vec[g]),
            .ready_o      (ready_vec[g]),
            .op_o         (slot_op[g]),
            .a_o          (slot_a[g]),
            .b_o          (slot_b[g])
        );
    end

    rs_age_pick #(
        .N     (N_ENTRIES),
        .TAG_W (TAG_W)
    ) i_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (alloc_vec),
        .ready_i     (ready_vec),
        .grant_o     (grant_vec),
        .grant_idx_o (grant_idx),
        .grant_any_o (grant_any)
    );

    assign issue_valid_o = grant_any;
    assign issue_tag_o   = grant_idx;
    assign issue_op_o    = slot_op[grant_idx];
    assign issue_a_o     = slot_a[grant_idx];
    assign issue_b_o     = slot_b[grant_idx];

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int N_ENTRIES = 4,
    parameter int TAG_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 disp_valid_i,
    input logic                 disp_ready_o,
    input logic                 issue_valid_o,
    input logic [TAG_W-1:0]     issue_tag_o,
    input logic                 bc_valid_i,
    input logic [TAG_W-1:0]     bc_tag_i,
    input logic [N_ENTRIES-1:0] busy_vec,
    input logic [N_ENTRIES-1:0] sent_vec,
    input logic [N_ENTRIES-1:0] grant_vec
);

    // R6: the picker never grants two slots at once
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R4: an issued tag belongs to an occupied slot not yet sent
    p_issue_from_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (busy_vec[issue_tag_o] && !sent_vec[issue_tag_o]));

    // R4: the same slot is not offered in two consecutive cycles
    p_issue_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |=> !(issue_valid_o && (issue_tag_o == $past(issue_tag_o))));

    // R2: a taken dispatch occupies exactly one more slot
    p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_i && disp_ready_o && !bc_valid_i) |=>
        ($countones(busy_vec) == $past($countones(busy_vec)) + 1));

    // R7: a broadcast of a sent slot's tag frees that slot
    p_free_after_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid_i && sent_vec[bc_tag_i]) |=> !busy_vec[$past(bc_tag_i)]);

    // R8: a full pool stays full while nothing is broadcast
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready_o && !bc_valid_i) |=> !disp_ready_o);

endmodule

bind rs_station rs_station_chk #(
    .N_ENTRIES (N_ENTRIES),
    .TAG_W     (TAG_W)
) i_rs_station_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .disp_valid_i  (disp_valid_i),
    .disp_ready_o  (disp_ready_o),
    .issue_valid_o (issue_valid_o),
    .issue_tag_o   (issue_tag_o),
    .bc_valid_i    (bc_valid_i),
    .bc_tag_i      (bc_tag_i),
    .busy_vec      (busy_vec),
    .sent_vec      (sent_vec),
    .grant_vec     (grant_vec)
);

// File: tb/test_rs_station.sv
module test_rs_station;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        dv;
        logic [3:0]  op;
        logic [2:0]  rd;
        logic [2:0]  rs1;
        logic [2:0]  rs2;
        logic        bv;
        logic [1:0]  bt;
        logic [15:0] bd;
        logic        xr;
        logic        xiv;
        logic [1:0]  xt;
        logic [3:0]  xo;
        logic [15:0] xa;
        logic [15:0] xb;
    } row_t;

    function automatic row_t mk(int dv, int op, int rd, int rs1, int rs2,
                                int bv, int bt, int bd,
                                int xr, int xiv, int xt, int xo, int xa, int xb);
        row_t r;
        r.dv = 1'(dv);   r.op = 4'(op);   r.rd = 3'(rd);
        r.rs1 = 3'(rs1); r.rs2 = 3'(rs2);
        r.bv = 1'(bv);   r.bt = 2'(bt);   r.bd = 16'(bd);
        r.xr = 1'(xr);   r.xiv = 1'(xiv); r.xt = 2'(xt);
        r.xo = 4'(xo);   r.xa = 16'(xa);  r.xb = 16'(xb);
        return r;
    endfunction

    // One row per cycle: dispatch, broadcast, then the outputs due in that cycle
    localparam row_t VEC [0:16] = '{
        mk(1,1,1,0,0, 0,0,0,      1,0,0,0,0,0),            // tag0 ready at load
        mk(1,2,2,1,0, 0,0,0,      1,1,0,1,0,0),            // waits on tag0
        mk(0,0,0,0,0, 1,0,'h11,   1,0,0,0,0,0),            // capture 0x11
        mk(1,3,3,1,2, 0,0,0,      1,1,1,2,'h11,0),         // reuses slot 0
        mk(1,4,4,2,1, 1,1,'h22,   1,0,0,0,0,0),            // same-cycle bypass
        mk(0,0,0,0,0, 0,0,0,      1,1,0,3,'h11,'h22),
        mk(0,0,0,0,0, 0,0,0,      1,1,2,4,'h22,'h11),
        mk(1,5,5,3,0, 0,0,0,      1,0,0,0,0,0),            // into slot 1
        mk(1,6,6,4,0, 0,0,0,      1,0,0,0,0,0),            // into slot 3
        mk(1,7,1,0,0, 0,0,0,      0,0,0,0,0,0),            // full: dropped
        mk(0,0,0,0,0, 1,2,'h44,   0,0,0,0,0,0),
        mk(1,8,7,5,6, 1,0,'h33,   1,1,3,6,'h44,0),
        mk(0,0,0,0,0, 0,0,0,      1,1,1,5,'h33,0),
        mk(0,0,0,0,0, 1,3,'h66,   1,0,0,0,0,0),
        mk(0,0,0,0,0, 1,1,'h55,   1,0,0,0,0,0),
        mk(0,0,0,0,0, 0,0,0,      1,1,2,8,'h55,'h66),
        mk(0,0,0,0,0, 1,2,'h77,   1,0,0,0,0,0)
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid_i;
    logic        disp_ready_o;
    logic [3:0]  disp_op_i;
    logic [2:0]  disp_rd_i, disp_rs1_i, disp_rs2_i;
    logic        issue_valid_o;
    logic [1:0]  issue_tag_o;
    logic [3:0]  issue_op_o;
    logic [15:0] issue_a_o, issue_b_o;
    logic        bc_valid_i;
    logic [1:0]  bc_tag_i;
    logic [15:0] bc_value_i;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_station i_rs_station (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_valid_i  (disp_valid_i),
        .disp_ready_o  (disp_ready_o),
        .disp_op_i     (disp_op_i),
        .disp_rd_i     (disp_rd_i),
        .disp_rs1_i    (disp_rs1_i),
        .disp_rs2_i    (disp_rs2_i),
        .issue_valid_o (issue_valid_o),
        .issue_tag_o   (issue_tag_o),
        .issue_op_o    (issue_op_o),
        .issue_a_o     (issue_a_o),
        .issue_b_o     (issue_b_o),
        .bc_valid_i    (bc_valid_i),
        .bc_tag_i      (bc_tag_i),
        .bc_value_i    (bc_value_i)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        disp_valid_i = 1'b0; disp_op_i = '0; disp_rd_i = '0;
        disp_rs1_i = '0; disp_rs2_i = '0;
        bc_valid_i = 1'b0; bc_tag_i = '0; bc_value_i = '0;
    endtask

    // Drive one cycle at the falling edge, sample just before the rising edge
    task automatic step(input row_t r, input string req_iss);
        @(negedge clk);
        disp_valid_i = r.dv;  disp_op_i = r.op;   disp_rd_i = r.rd;
        disp_rs1_i = r.rs1;   disp_rs2_i = r.rs2;
        bc_valid_i = r.bv;    bc_tag_i = r.bt;    bc_value_i = r.bd;
        #(CLK_PERIOD / 2 - 1);
        check(disp_ready_o == r.xr, "R8", "disp_ready", int'(disp_ready_o), int'(r.xr));
        check(issue_valid_o == r.xiv, req_iss, "issue_valid", int'(issue_valid_o), int'(r.xiv));
        if (r.xiv && issue_valid_o) begin
            check(issue_tag_o == r.xt, "R2", "issue_tag", int'(issue_tag_o), int'(r.xt));
            check(issue_op_o == r.xo, req_iss, "issue_op", int'(issue_op_o), int'(r.xo));
            check(issue_a_o == r.xa, "R3/R5", "issue_a", int'(issue_a_o), int'(r.xa));
            check(issue_b_o == r.xb, "R3/R5", "issue_b", int'(issue_b_o), int'(r.xb));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing to issue, dispatch open
        step(mk(0,0,0,0,0, 0,0,0, 1,0,0,0,0,0), "R1");

        // Vector walk covering R2 R3 R4 R5 R7 R8
        for (int i = 0; i <= 16; i++) begin
            step(VEC[i], "R4");
        end

        // R6: slot 2 was loaded before slot 0; age beats index
        step(mk(1,9,1,0,0,   0,0,0,       1,0,0,0,0,0), "R6");
        step(mk(1,10,2,1,0,  0,0,0,       1,1,0,9,0,0), "R6");
        step(mk(1,11,3,1,1,  0,0,0,       1,0,0,0,0,0), "R6");
        step(mk(0,0,0,0,0,   1,0,'h100,   1,0,0,0,0,0), "R6");
        step(mk(1,12,4,0,0,  0,0,0,       1,1,1,10,'h100,0), "R6");
        step(mk(0,0,0,0,0,   0,0,0,       1,1,2,11,'h100,'h100), "R6");
        step(mk(0,0,0,0,0,   0,0,0,       1,1,0,12,0,0), "R6");
        step(mk(0,0,0,0,0,   1,1,'h200,   1,0,0,0,0,0), "R7");
        step(mk(0,0,0,0,0,   1,2,'h300,   1,0,0,0,0,0), "R7");
        step(mk(0,0,0,0,0,   1,0,'h400,   1,0,0,0,0,0), "R7");

        // R9 R10 R11: two writers of r5 in flight, stale broadcast must not land
        step(mk(1,1,5,5,0,   0,0,0,       1,0,0,0,0,0), "R11");
        step(mk(1,2,6,5,5,   0,0,0,       1,1,0,1,'h55,0), "R11");
        step(mk(1,3,5,0,0,   0,0,0,       1,0,0,0,0,0), "R9");
        step(mk(1,4,7,5,0,   0,0,0,       1,1,2,3,0,0), "R9");
        step(mk(0,0,0,0,0,   1,0,'hAAA,   0,0,0,0,0,0), "R10");
        step(mk(1,5,1,5,5,   0,0,0,       1,1,1,2,'hAAA,'hAAA), "R9");
        step(mk(0,0,0,0,0,   1,2,'hBBB,   0,0,0,0,0,0), "R10");
        step(mk(0,0,0,0,0,   0,0,0,       1,1,3,4,'hBBB,0), "R10");
        step(mk(0,0,0,0,0,   0,0,0,       1,1,0,5,'hBBB,'hBBB), "R10");

        // R1: reset mid-run clears values and pending producers
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(mk(0,0,0,0,0,   0,0,0,       1,0,0,0,0,0), "R1");
        step(mk(1,6,1,5,7,   0,0,0,       1,0,0,0,0,0), "R1");
        step(mk(0,0,0,0,0,   0,0,0,       1,1,0,6,0,0), "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule